// File: doc/BRIEF.md
# Memory Stage Access Controller

This block turns the opcode of the instruction now in its memory step into one data-memory request and serves that request from a small internal byte-addressed array. Each opcode picks where the address comes from: the ALU result or the unmodified source operand. It also picks what is written: the source operand or the address of the following instruction. Words are four bytes wide, and byte 0 of a word holds its least significant bits. Reads are combinational, so the loaded word is available in the same cycle. Writes land on the rising clock edge.

Pop and return take their address from the old stack pointer, which arrives as the source operand. Push and call take theirs from the ALU result, which holds the decremented pointer. A word that would run past the end of the array raises an error flag. A store to such an address is dropped and a load from it returns zero.

Top module: `mem_stage_ctrl`

## Requirements
- R1: The opcode is 4 bits wide, encoded stop=1, idle=0, register move=2, immediate move=3, store=4, load=5, ALU operation=6, branch=7, call=8, return=9, push=10, pop=11. `mem_addr` equals `alu_result` for store, load, push and call, and equals `src_value` for pop and return.
- R2: `rd_en` is 1 exactly for load, pop and return.
- R3: `wr_en` is 1 exactly for store, push and call. This holds even when the address is out of range.
- R4: `wr_data` equals `src_value` for store and push, equals `next_pc` for call, and is 0 for every other opcode.
- R5: For idle, stop, register move, immediate move, ALU operation, branch and codes 12 to 15, `mem_addr` and `rd_data` are 0, `addr_err` is 0 and no memory byte changes.
- R6: Byte N of the array holds bits 8N' to 8N'+7 of a word placed at address A, where N' = N - A, for N from A to A+3. A read at any byte address, aligned or not, assembles its word in the same way.
- R7: While `rd_en` is 1 and the address is in range, `rd_data` shows the current array contents without a clock edge. A write becomes visible only after the next rising edge.
- R8: An access whose last byte (address + 3) lies at or beyond `MEM_BYTES` sets `addr_err`. Such a write changes no byte, and such a read returns 0.
- R9: A synchronous active-high `rst` clears every memory byte to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the array |
| opcode | input | 4 | Instruction class in the memory step |
| alu_result | input | 32 | ALU output (computed address or adjusted stack pointer) |
| src_value | input | 32 | First register operand (store data or old stack pointer) |
| next_pc | input | 32 | Address of the following instruction |
| mem_addr | output | 32 | Selected byte address, 0 when no access |
| rd_en | output | 1 | Read requested |
| wr_en | output | 1 | Write requested |
| wr_data | output | 32 | Selected write word |
| rd_data | output | 32 | Word read, little-endian, 0 when not read |
| addr_err | output | 1 | Access runs past the end of the array |

## Verification
All sixteen opcode values are swept against eight address patterns: word-aligned, odd, the last legal word, the first and a later out-of-range word, and one near the top of the address space. Because `alu_result` and `src_value` carry different values on every step, a swapped address or data source shows up at once. Interleaving stores, pushes and calls with loads, pops and returns over overlapping bytes separates wrong byte order and wrong lane offsets from missed or mistimed commits. Dedicated cases change the opcode mid-cycle to expose a write that lands before its edge, aim a store at the last three bytes to expose a partial out-of-range write, and reset after a write to expose an array that is not cleared.

// File: rtl/mem_stage_pkg.sv
package mem_stage_pkg;

    localparam int WORD_BYTES = 4;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;

    typedef enum logic [3:0] {
        OPC_IDLE    = 4'h0,
        OPC_STOP    = 4'h1,
        OPC_MOVE_RR = 4'h2,
        OPC_MOVE_IR = 4'h3,
        OPC_STORE   = 4'h4,
        OPC_LOAD    = 4'h5,
        OPC_ALU     = 4'h6,
        OPC_BRANCH  = 4'h7,
        OPC_CALL    = 4'h8,
        OPC_RETURN  = 4'h9,
        OPC_PUSH    = 4'hA,
        OPC_POP     = 4'hB
    } opcode_e;

    typedef enum logic {
        ADDR_FROM_ALU,
        ADDR_FROM_SRC
    } addr_sel_e;

    typedef enum logic [1:0] {
        DATA_NONE,
        DATA_FROM_SRC,
        DATA_FROM_PC
    } data_sel_e;

    typedef struct packed {
        logic      rd;
        logic      wr;
        addr_sel_e addr_sel;
        data_sel_e data_sel;
    } access_ctl_t;

    // Per-opcode access plan; unlisted codes make no access.
    function automatic access_ctl_t decode_access(input logic [3:0] code);
        access_ctl_t c;
        c = '{rd: 1'b0, wr: 1'b0, addr_sel: ADDR_FROM_ALU, data_sel: DATA_NONE};
        case (code)
            OPC_STORE:  begin c.wr = 1'b1; c.data_sel = DATA_FROM_SRC; end
            OPC_PUSH:   begin c.wr = 1'b1; c.data_sel = DATA_FROM_SRC; end
            OPC_CALL:   begin c.wr = 1'b1; c.data_sel = DATA_FROM_PC;  end
            OPC_LOAD:   begin c.rd = 1'b1; end
            OPC_POP:    begin c.rd = 1'b1; c.addr_sel = ADDR_FROM_SRC; end
            OPC_RETURN: begin c.rd = 1'b1; c.addr_sel = ADDR_FROM_SRC; end
            default:    c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ms_access_decode.sv
module ms_access_decode
    import mem_stage_pkg::*;
(
    input  logic [3:0]  opcode,
    output access_ctl_t ctl
);

    always_comb begin
        ctl = decode_access(opcode);
    end

endmodule

// File: rtl/ms_range_check.sv
module ms_range_check #(
    parameter int ADDR_W     = 32,
    parameter int MEM_BYTES  = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);

    // Highest start address whose whole word still fits.
    localparam logic [ADDR_W-1:0] LAST_START = ADDR_W'(MEM_BYTES - WORD_BYTES);

    always_comb begin
        in_range = (addr <= LAST_START);
    end

endmodule

// File: rtl/ms_byte_store.sv
module ms_byte_store #(
    parameter int MEM_BYTES  = 64,
    parameter int WORD_BYTES = 4,
    parameter int BYTE_W     = 8,
    localparam int IDX_W     = $clog2(MEM_BYTES),
    localparam int WORD_W    = WORD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [MEM_BYTES];
    logic [IDX_W-1:0]  lane_idx [WORD_BYTES];

    // Lane k maps to byte addr+k; lane 0 carries the low-order bits.
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        assign lane_idx[k] = addr + IDX_W'(k);

        always_comb begin
            if (int'(lane_idx[k]) < MEM_BYTES)
                rdata[k*BYTE_W +: BYTE_W] = mem[lane_idx[k]];
            else
                rdata[k*BYTE_W +: BYTE_W] = '0;
        end

        // R7: a committed lane holds the written byte after the edge
        p_lane_commit_r7: assert property (@(posedge clk) disable iff (rst)
            we |=> mem[$past(lane_idx[k])] == $past(wdata[k*BYTE_W +: BYTE_W]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
        end else if (we) begin
            for (int k = 0; k < WORD_BYTES; k++)
                mem[lane_idx[k]] <= wdata[k*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/mem_stage_ctrl.sv
module mem_stage_ctrl
    import mem_stage_pkg::*;
#(
    parameter int MEM_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        opcode,
    input  logic [WORD_W-1:0] alu_result,
    input  logic [WORD_W-1:0] src_value,
    input  logic [WORD_W-1:0] next_pc,
    output logic [WORD_W-1:0] mem_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              addr_err
);

    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam logic [WORD_W-1:0] LAST_START = WORD_W'(MEM_BYTES - WORD_BYTES);

    access_ctl_t       ctl;
    logic              accessing;
    logic              in_range;
    logic              commit;
    logic [WORD_W-1:0] sel_addr;
    logic [WORD_W-1:0] raw_word;

    ms_access_decode u_decode (
        .opcode (opcode),
        .ctl    (ctl)
    );

    always_comb begin
        sel_addr  = (ctl.addr_sel == ADDR_FROM_SRC) ? src_value : alu_result;
        accessing = ctl.rd | ctl.wr;
        mem_addr  = accessing ? sel_addr : '0;
        rd_en     = ctl.rd;
        wr_en     = ctl.wr;
        case (ctl.data_sel)
            DATA_FROM_SRC: wr_data = src_value;
            DATA_FROM_PC:  wr_data = next_pc;
            default:       wr_data = '0;
        endcase
    end

    ms_range_check #(
        .ADDR_W     (WORD_W),
        .MEM_BYTES  (MEM_BYTES),
        .WORD_BYTES (WORD_BYTES)
    ) u_range (
        .addr     (sel_addr),
        .in_range (in_range)
    );

    always_comb begin
        addr_err = accessing & ~in_range;
        commit   = ctl.wr & in_range;
        rd_data  = (ctl.rd && in_range) ? raw_word : '0;
    end

    ms_byte_store #(
        .MEM_BYTES  (MEM_BYTES),
        .WORD_BYTES (WORD_BYTES),
        .BYTE_W     (BYTE_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .addr  (sel_addr[IDX_W-1:0]),
        .wdata (wr_data),
        .rdata (raw_word)
    );

    // R1: stack pops and returns address through the old pointer
    p_pop_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_POP || opcode == OPC_RETURN) |-> mem_addr == src_value);
    // R1: push and call address through the ALU result
    p_push_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_PUSH || opcode == OPC_CALL) |-> mem_addr == alu_result);
    // R2: reads only for load, pop, return
    p_read_ops_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (opcode == OPC_LOAD || opcode == OPC_POP || opcode == OPC_RETURN));
    // R3: writes only for store, push, call, never together with a read
    p_write_ops_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!rd_en && (opcode == OPC_STORE || opcode == OPC_PUSH || opcode == OPC_CALL)));
    // R4: call pushes the return address
    p_call_data_r4: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_CALL) |-> wr_data == next_pc);
    // R5: no request leaves the outputs quiet
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |-> (mem_addr == '0 && rd_data == '0 && !addr_err));
    // R8: error flag only past the last word start, and a faulted read gives 0
    p_err_bound_r8: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (mem_addr > LAST_START && rd_data == '0));

endmodule

// File: tb/mem_stage_ctrl_test.sv
module mem_stage_ctrl_test;

    localparam int MB = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'h0;
    logic [31:0] alu_result = '0, src_value = '0, next_pc = '0;
    logic [31:0] mem_addr, wr_data, rd_data;
    logic        rd_en, wr_en, addr_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic [7:0] mdl [MB];

    always #4 clk = ~clk;

    mem_stage_ctrl #(.MEM_BYTES(MB)) uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_result(alu_result),
        .src_value(src_value), .next_pc(next_pc), .mem_addr(mem_addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .addr_err(addr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mdl_word(input logic [31:0] a);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = mdl[int'(a) + k];
        return w;
    endfunction

    function automatic logic [31:0] addr_pat(input int i);
        case (i)
            0: return 32'd0;
            1: return 32'd4;
            2: return 32'd13;
            3: return 32'd33;
            4: return 32'd59;
            5: return 32'd60;
            6: return 32'd61;
            default: return 32'hFFFF_FFFD;
        endcase
    endfunction

    // Drive one opcode for one cycle, check every output, then advance the model.
    task automatic step(input int op, input logic [31:0] a, input logic [31:0] s,
                        input logic [31:0] p);
        bit erd = 0, ewr = 0, inr, acc;
        logic [31:0] ea = '0, ed = '0, eaddr, erdata;
        @(negedge clk);
        opcode = op[3:0]; alu_result = a; src_value = s; next_pc = p;
        #1;
        case (op)
            4:  begin ewr = 1; ea = a; ed = s; end
            5:  begin erd = 1; ea = a; end
            8:  begin ewr = 1; ea = a; ed = p; end
            9:  begin erd = 1; ea = s; end
            10: begin ewr = 1; ea = a; ed = s; end
            11: begin erd = 1; ea = s; end
            default: ;
        endcase
        acc    = erd | ewr;
        inr    = (ea <= 32'(MB - 4));
        eaddr  = acc ? ea : 32'd0;
        erdata = (erd && inr) ? mdl_word(ea) : 32'd0;
        chk(acc ? "R1 address" : "R5 address", mem_addr, eaddr);
        chk("R2 read enable", {31'd0, rd_en}, {31'd0, erd});
        chk("R3 write enable", {31'd0, wr_en}, {31'd0, ewr});
        chk("R4 write data", wr_data, ed);
        chk(acc ? "R7 read data" : "R5 read data", rd_data, erdata);
        chk(acc ? "R8 error flag" : "R5 error flag", {31'd0, addr_err}, {31'd0, acc && !inr});
        @(posedge clk);
        if (ewr && inr)
            for (int k = 0; k < 4; k++) mdl[int'(ea) + k] = ed[k*8 +: 8];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MB; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset state and R9: cleared array, idle outputs
        #1;
        chk("R5 reset address", mem_addr, 32'd0);
        chk("R5 reset read data", rd_data, 32'd0);
        step(5, 32'd20, 32'd0, 32'd0);

        // Full sweep of opcodes against address patterns
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                step(op, addr_pat(i),
                     (op == 9 || op == 11) ? addr_pat((i + 3) % 8)
                                           : 32'h0102_0304 * (op + 1) + 32'h1111_0000 * i,
                     32'h0000_0800 + 32'(op * 16 + i));

        // R6: byte order, aligned and unaligned reads
        step(4, 32'd16, 32'h4433_2211, 32'd0);
        @(negedge clk); opcode = 4'h5; alu_result = 32'd16; #1;
        chk("R6 aligned word", rd_data, 32'h4433_2211);
        alu_result = 32'd17; #1;
        chk("R6 unaligned low bytes", {8'd0, rd_data[23:0]}, 32'h0044_3322);
        step(11, 32'd0, 32'd18, 32'd0);

        // R7: write is not visible before its edge
        step(10, 32'd40, 32'hCAFE_F00D, 32'd0);
        @(negedge clk); opcode = 4'h4; alu_result = 32'd40; src_value = 32'h1234_5678; #1;
        opcode = 4'h5; #1;
        chk("R7 old value before edge", rd_data, 32'hCAFE_F00D);
        opcode = 4'h4; #1;
        @(posedge clk);
        @(negedge clk); opcode = 4'h5; #1;
        chk("R7 new value after edge", rd_data, 32'h1234_5678);
        for (int k = 0; k < 4; k++) mdl[40 + k] = 8'(32'h1234_5678 >> (8 * k));

        // R8: partial word at the end is refused and leaves bytes intact
        step(4, 32'd60, 32'hA1B2_C3D4, 32'd0);
        step(8, 32'd61, 32'd0, 32'h7777_7777);
        @(negedge clk); opcode = 4'h5; alu_result = 32'd60; #1;
        chk("R8 write suppressed", rd_data, 32'hA1B2_C3D4);

        // R9: synchronous reset clears the array
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < MB; i++) mdl[i] = 8'h00;
        opcode = 4'h5; alu_result = 32'd16; #1;
        chk("R9 cleared after reset", rd_data, 32'd0);
        alu_result = 32'd40; #1;
        chk("R9 cleared after reset", rd_data, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule